// File: doc/BRIEF.md
# Instruction Pattern Classifier

This block sorts a 32-bit instruction word into one of the entries of an ordered pattern table. Each table entry carries a list of field rules. A field rule names a low bit position, a high bit position and the value that the bits between them must hold. Each entry also carries a second, optional list of field rules that works as a veto. When every rule in that veto list holds, the entry is rejected even though its own rules all hold.

A request is a word presented with `in_valid`. Two clock edges later the block raises `out_valid` for one cycle. With it, the block reports whether some entry accepted the word, and the zero-based table position of the lowest-numbered entry that did. The table is a set of synthesizable constants in the package. A demonstration table of twelve entries ships with the block. The scan is fully pipelined, so a new request can enter on every cycle.

Top module: `instr_pattern_classifier`

## Requirements
- R1: A field rule (lo, hi, value) holds when instr[hi:lo] equals value. An entry's own list is satisfied only when each of its first n rules holds, where n is the list's count (0 to 7). Rule slots at or above n have no effect. Single-bit rules (lo = hi) are included.
- R2: When an entry's veto count is nonzero and each of its first veto-count veto rules holds, that entry is not accepted, even if its own list is satisfied.
- R3: An entry whose veto count is zero is accepted whenever its own list is satisfied, whatever the instruction holds in any other bits.
- R4: When several entries accept the word, `idx` reports the lowest table position among them. `idx` is the zero-based position in the table.
- R5: A vetoed entry does not stop the search. A later entry that accepts the same word is reported.
- R6: When no entry accepts the word, `hit` is 0 and `idx` is 0 in the result cycle.
- R7: Each cycle in which `in_valid` is 1 at a rising edge produces `out_valid` = 1 for exactly one cycle, two rising edges later. The result belongs to the word presented with that request. Back-to-back requests give back-to-back results. Cycles in which `in_valid` is 0 produce no result, whatever `instr` holds.
- R8: While `rst_n` is 0 at a rising edge (synchronous, active low), `out_valid`, `hit` and `idx` are 0 after that edge, and requests in flight are dropped.
- R9: A rule that spans the whole word (lo = 0, hi = 31) matches only the exact 32-bit value. A word that differs from that value in bit 0 alone does not match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe for `instr` |
| instr | input | 32 | Instruction word to classify |
| out_valid | output | 1 | Result strobe, one cycle per request |
| hit | output | 1 | 1 when some entry accepted the word |
| idx | output | IDX_W (4 by default) | Position of the first accepting entry, 0 when `hit` is 0 |

## Verification
The bench builds the block with its defaults: a 32-bit word, seven rule slots per list and the twelve-entry demonstration table. With these values, one entry fills all seven of its slots, so the check on the slot count reaches its upper edge. Other entries use a whole-word rule and single-bit rules. Several entries overlap, so both first-match priority and fall-through after a veto occur. Random words are seeded by forcing the fields of a randomly chosen entry, and sometimes its veto fields as well, so that accepts, vetoes and misses all occur often next to fully random words.

// File: rtl/ipc_pkg.sv
// Package for the instruction pattern classifier.
// Holds the sizes, the rule and pattern types, and the demonstration table.
// Assumes every rule has hi >= lo and a value that fits in hi-lo+1 bits.
package ipc_pkg;

    localparam int INSTR_W     = 32;
    localparam int POS_W       = $clog2(INSTR_W);
    localparam int MAX_TRIPLES = 7;
    localparam int CNT_W       = $clog2(MAX_TRIPLES + 1);
    localparam int TABLE_DEPTH = 12;

    typedef struct packed {
        logic [POS_W-1:0]   lo;
        logic [POS_W-1:0]   hi;
        logic [INSTR_W-1:0] val;
    } field_rule_t;

    typedef struct packed {
        logic [CNT_W-1:0]                    n;
        field_rule_t [MAX_TRIPLES-1:0] rule;
    } rule_list_t;

    typedef struct packed {
        rule_list_t need;
        rule_list_t veto;
    } pattern_t;

    // Build one field rule from integer bounds and a value.
    function automatic field_rule_t fr(input int lo, input int hi, input logic [INSTR_W-1:0] v);
        field_rule_t r;
        r.lo  = POS_W'(lo);
        r.hi  = POS_W'(hi);
        r.val = v;
        return r;
    endfunction

    // Return the pattern stored at table position k.
    function automatic pattern_t pattern_at(input int k);
        pattern_t p;
        p = '0;
        case (k)
            0: begin
                p.need.n = CNT_W'(2);
                p.need.rule[0] = fr(28, 31, 32'hF);
                p.need.rule[1] = fr(24, 27, 32'hE);
                p.veto.n = CNT_W'(1);
                p.veto.rule[0] = fr(4, 4, 32'h1);
            end
            1: begin
                p.need.n = CNT_W'(1);
                p.need.rule[0] = fr(25, 27, 32'h5);
            end
            2: begin
                p.need.n = CNT_W'(2);
                p.need.rule[0] = fr(26, 27, 32'h1);
                p.need.rule[1] = fr(20, 20, 32'h1);
                p.veto.n = CNT_W'(2);
                p.veto.rule[0] = fr(16, 19, 32'hF);
                p.veto.rule[1] = fr(12, 15, 32'hF);
            end
            3: begin
                p.need.n = CNT_W'(1);
                p.need.rule[0] = fr(26, 27, 32'h1);
            end
            4: begin
                p.need.n = CNT_W'(2);
                p.need.rule[0] = fr(21, 27, 32'h0D);
                p.need.rule[1] = fr(4, 4, 32'h0);
                p.veto.n = CNT_W'(1);
                p.veto.rule[0] = fr(12, 15, 32'hF);
            end
            5: begin
                p.need.n = CNT_W'(1);
                p.need.rule[0] = fr(0, 31, 32'hE320F000);
            end
            6: begin
                p.need.n = CNT_W'(4);
                p.need.rule[0] = fr(23, 27, 32'h02);
                p.need.rule[1] = fr(20, 21, 32'h0);
                p.need.rule[2] = fr(4, 7, 32'h0);
                p.need.rule[3] = fr(8, 11, 32'h0);
            end
            7: begin
                p.need.n = CNT_W'(7);
                p.need.rule[0] = fr(24, 27, 32'h0);
                p.need.rule[1] = fr(23, 23, 32'h0);
                p.need.rule[2] = fr(22, 22, 32'h0);
                p.need.rule[3] = fr(21, 21, 32'h1);
                p.need.rule[4] = fr(7, 7, 32'h1);
                p.need.rule[5] = fr(5, 6, 32'h0);
                p.need.rule[6] = fr(4, 4, 32'h1);
                p.veto.n = CNT_W'(2);
                p.veto.rule[0] = fr(0, 3, 32'hF);
                p.veto.rule[1] = fr(12, 15, 32'hF);
            end
            8: begin
                p.need.n = CNT_W'(2);
                p.need.rule[0] = fr(25, 27, 32'h0);
                p.need.rule[1] = fr(4, 4, 32'h0);
                p.veto.n = CNT_W'(2);
                p.veto.rule[0] = fr(23, 24, 32'h2);
                p.veto.rule[1] = fr(20, 20, 32'h0);
            end
            9: begin
                p.need.n = CNT_W'(1);
                p.need.rule[0] = fr(25, 27, 32'h1);
            end
            10: begin
                p.need.n = CNT_W'(1);
                p.need.rule[0] = fr(24, 27, 32'hF);
            end
            11: begin
                p.need.n = CNT_W'(1);
                p.need.rule[0] = fr(25, 27, 32'h6);
                p.veto.n = CNT_W'(1);
                p.veto.rule[0] = fr(28, 31, 32'hF);
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ipc_field_cmp.sv
// Compares one bit field of the word against a rule's value.
// Assumes rule.hi >= rule.lo; a span of the full word is allowed.
module ipc_field_cmp
    import ipc_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    input  field_rule_t        rule,
    output logic               holds
);
    logic [POS_W:0]   span;
    logic [INSTR_W:0] span_mask;

    // Form the field mask from the span and compare the aligned field.
    always_comb begin
        span      = {1'b0, rule.hi} - {1'b0, rule.lo} + (POS_W+1)'(1);
        span_mask = ((INSTR_W+1)'(1) << span) - (INSTR_W+1)'(1);
        holds     = ((word >> rule.lo) & span_mask[INSTR_W-1:0]) == rule.val;
    end
endmodule

// File: rtl/ipc_rule_list.sv
// Evaluates a counted list of field rules: true when every used slot holds.
// Assumes list.n <= MAX_TRIPLES; a count of zero yields true.
module ipc_rule_list
    import ipc_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    input  rule_list_t         list,
    output logic               all_hold
);
    logic [MAX_TRIPLES-1:0] slot_ok;
    logic [MAX_TRIPLES-1:0] slot_used;

    for (genvar s = 0; s < MAX_TRIPLES; s++) begin : g_slot
        ipc_field_cmp u_cmp (
            .word  (word),
            .rule  (list.rule[s]),
            .holds (slot_ok[s])
        );
        assign slot_used[s] = CNT_W'(s) < list.n;
    end

    // A slot counts only when it lies below the list count.
    always_comb all_hold = &(slot_ok | ~slot_used);
endmodule

// File: rtl/ipc_entry_eval.sv
// Decides whether one table entry accepts the word: its own list is
// satisfied and its veto list (when its count is nonzero) is not.
// Assumes PAT is a constant taken from the package table.
module ipc_entry_eval
    import ipc_pkg::*;
#(
    parameter pattern_t PAT = '0
) (
    input  logic [INSTR_W-1:0] word,
    output logic               need_ok,
    output logic               vetoed,
    output logic               accept
);
    logic veto_all;

    ipc_rule_list u_need (.word(word), .list(PAT.need), .all_hold(need_ok));
    ipc_rule_list u_veto (.word(word), .list(PAT.veto), .all_hold(veto_all));

    // An empty veto list never rejects; otherwise all its rules must hold.
    always_comb begin
        vetoed = (PAT.veto.n != '0) && veto_all;
        accept = need_ok && !vetoed;
    end
endmodule

// File: rtl/ipc_first_pick.sv
// Registers the lowest-numbered set bit of the accept vector as the result.
// Assumes acc is all zero when v_in is low.
module ipc_first_pick #(
    parameter int N     = 12,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  logic [N-1:0]     acc,
    output logic             out_valid,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic             found;
    logic [IDX_W-1:0] pos;

    // Priority search: the lowest set position wins.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (acc[k]) begin
                found = 1'b1;
                pos   = IDX_W'(k);
            end
        end
    end

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hit       <= 1'b0;
            idx       <= '0;
        end else begin
            out_valid <= v_in;
            hit       <= v_in && found;
            idx       <= v_in ? pos : '0;
        end
    end

    // R4: a reported hit points at a set accept bit
    p_idx_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit) |-> ((($past(acc) >> idx) & N'(1)) != '0));

    // R4: no accept bit below the reported position
    p_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hit) |-> (($past(acc) & ((N'(1) << idx) - N'(1))) == '0));

    // R6: no accepting entry gives hit low and idx zero
    p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(acc) == '0)) |-> (!hit && idx == '0));
endmodule

// File: rtl/instr_pattern_classifier.sv
// Top of the instruction pattern classifier. Stage 1 evaluates every
// table entry in parallel and registers the accept vector; stage 2
// registers the first accepting position. Latency is two edges.
// Assumes the table in ipc_pkg holds at least N_ENTRIES entries.
module instr_pattern_classifier
    import ipc_pkg::*;
#(
    parameter int N_ENTRIES = TABLE_DEPTH,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic               out_valid,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    logic [N_ENTRIES-1:0] acc_c;
    logic [N_ENTRIES-1:0] need_c;
    logic [N_ENTRIES-1:0] veto_c;
    logic [N_ENTRIES-1:0] acc_q;
    logic                 v_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        localparam pattern_t PAT = pattern_at(g);

        ipc_entry_eval #(.PAT(PAT)) u_eval (
            .word    (instr),
            .need_ok (need_c[g]),
            .vetoed  (veto_c[g]),
            .accept  (acc_c[g])
        );

        // R1: an unsatisfied own list never reaches the accept register
        p_need_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !need_c[g]) |=> !acc_q[g]);

        // R2: a vetoed entry is not accepted
        p_veto_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && veto_c[g]) |=> !acc_q[g]);

        if (PAT.veto.n == '0) begin : g_noveto
            // R3: entries without a veto list accept whenever satisfied
            p_noveto_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && need_c[g]) |=> acc_q[g]);
        end
    end

    // Stage 1 register: request flag and per-entry accept vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            acc_q <= '0;
        end else begin
            v_q   <= in_valid;
            acc_q <= in_valid ? acc_c : '0;
        end
    end

    ipc_first_pick #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .v_in      (v_q),
        .acc       (acc_q),
        .out_valid (out_valid),
        .hit       (hit),
        .idx       (idx)
    );

    // R7: a result appears only behind a stage-1 request
    p_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(v_q));

    // R7: every stage-1 request yields a result on the next edge
    p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |=> out_valid);
endmodule

// File: tb/tb_instr_pattern_classifier.sv
`timescale 1ns/1ps
module tb_instr_pattern_classifier;
    import ipc_pkg::*;

    localparam int IW    = $clog2(TABLE_DEPTH);
    localparam int LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic          out_valid;
    logic          hit;
    logic [IW-1:0] idx;

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R7";
    bit    done = 0;

    // Model pipeline: slot 0 is one edge old, slot 1 is due now.
    bit    exp_v [2];
    bit    exp_h [2];
    int    exp_i [2];
    string exp_t [2];
    bit    live = 0;

    always #2 clk = ~clk;

    instr_pattern_classifier dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .out_valid(out_valid), .hit(hit), .idx(idx)
    );

    function automatic bit list_ok(input logic [31:0] w, input rule_list_t l);
        for (int i = 0; i < int'(l.n); i++) begin
            for (int b = int'(l.rule[i].lo); b <= int'(l.rule[i].hi); b++)
                if (w[b] !== l.rule[i].val[b - int'(l.rule[i].lo)]) return 0;
        end
        return 1;
    endfunction

    task automatic ref_classify(input logic [31:0] w, output bit h, output int at);
        pattern_t p;
        h = 0; at = 0;
        for (int e = 0; e < TABLE_DEPTH; e++) begin
            p = pattern_at(e);
            if (list_ok(w, p.need) && !(int'(p.veto.n) != 0 && list_ok(w, p.veto))) begin
                h = 1; at = e;
                break;
            end
        end
    endtask

    always @(posedge clk) begin
        bit rh; int ri;
        if (!rst_n) begin
            live <= 1'b0;
            for (int k = 0; k < 2; k++) begin exp_v[k] <= 0; exp_h[k] <= 0; exp_i[k] <= 0; exp_t[k] <= "R8"; end
        end else begin
            live <= 1'b1;
            ref_classify(instr, rh, ri);
            exp_v[0] <= in_valid;
            exp_h[0] <= in_valid && rh;
            exp_i[0] <= in_valid ? ri : 0;
            exp_t[0] <= cur_tag;
            exp_v[1] <= exp_v[0];
            exp_h[1] <= exp_h[0];
            exp_i[1] <= exp_i[0];
            exp_t[1] <= exp_t[0];
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            checks++;
            if (out_valid !== exp_v[1]) begin
                failures++;
                $display("FAIL %s out_valid actual=%0b expected=%0b", exp_v[1] ? exp_t[1] : "R7", out_valid, exp_v[1]);
            end else if (exp_v[1]) begin
                checks++;
                if (hit !== exp_h[1] || int'(idx) != exp_i[1]) begin
                    failures++;
                    $display("FAIL %s hit/idx actual=%0b/%0d expected=%0b/%0d", exp_t[1], hit, idx, exp_h[1], exp_i[1]);
                end
            end
        end
    end

    task automatic send(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_valid = 1'b1; instr = w; cur_tag = tag;
    endtask

    task automatic gap(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; instr = $urandom; cur_tag = "R7";
        end
    endtask

    // Random word with one entry's fields forced, optionally its veto too.
    function automatic logic [31:0] seeded(input int e, input bit with_veto);
        pattern_t p = pattern_at(e);
        logic [31:0] w = $urandom;
        for (int i = 0; i < int'(p.need.n); i++)
            for (int b = int'(p.need.rule[i].lo); b <= int'(p.need.rule[i].hi); b++)
                w[b] = p.need.rule[i].val[b - int'(p.need.rule[i].lo)];
        if (with_veto)
            for (int i = 0; i < int'(p.veto.n); i++)
                for (int b = int'(p.veto.rule[i].lo); b <= int'(p.veto.rule[i].hi); b++)
                    w[b] = p.veto.rule[i].val[b - int'(p.veto.rule[i].lo)];
        return w;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * LIMIT);
        failures++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        in_valid = 1'b1; instr = 32'hE320F000;
        repeat (3) @(negedge clk);
        // R8: outputs held at zero during reset even with a request present
        checks++;
        if (out_valid !== 1'b0 || hit !== 1'b0 || idx !== '0) begin
            failures++;
            $display("FAIL R8 reset actual=%0b/%0b/%0d expected=0/0/0", out_valid, hit, idx);
        end
        rst_n = 1'b1; in_valid = 1'b0;
        gap(3);
        send(32'hE7912003, "R1");   // entry 2 satisfied, veto misses
        send(32'hE0200090, "R1");   // seven-rule entry accepted
        send(32'hE0200080, "R1");   // single-bit rule of entry 7 fails
        send(32'hFE000010, "R2");   // entry 0 vetoed by bit 4
        send(32'hE020F09F, "R2");   // entry 7 vetoed
        send(32'hFE000000, "R4");   // entry 0 accepted
        send(32'hEA000000, "R3");   // entry 1, no veto list
        send(32'hE59FF000, "R5");   // entry 2 vetoed, entry 3 reports
        send(32'hE320F000, "R9");   // whole-word rule
        send(32'hE320F001, "R9");   // bit 0 differs: falls to entry 9
        send(32'h00000000, "R6");
        send(32'hFC000000, "R6");   // entry 11 vetoed, nothing else
        gap(2);
        send(32'h12345678, "R7");
        gap(1);
        // Seeded and random traffic with bursts and gaps.
        for (int n = 0; n < 600; n++) begin
            int e = $urandom_range(TABLE_DEPTH - 1);
            case ($urandom_range(3))
                0: send(seeded(e, 1'b0), "R4");
                1: send(seeded(e, 1'b1), "R5");
                2: send($urandom, "R6");
                default: send(seeded(e, 1'b0), "R3");
            endcase
            if ($urandom_range(7) == 0) gap($urandom_range(3) + 1);
        end
        // R8: reset mid-stream drops requests in flight
        send(32'hEA000000, "R8");
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R8 flush actual=%0b expected=0", out_valid);
        end
        @(negedge clk); rst_n = 1'b1;
        send(32'hE59FF000, "R5");
        gap(4);
        finish_run();
    end
endmodule